// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

This block is a synchronous static RAM. Its command pipeline lets a read and a write sit on back-to-back clock cycles with no idle cycle between them. On every enabled clock edge it takes one of three commands: a new read, a new write, or a continue of the current four-word burst. The data phase of each command comes two edges after its command edge. Write data is sampled then, and read data is registered then and presented from that edge onward. Because every command has the same fixed distance between command and data, the shared data buses never have to turn around.

A new command needs all three chip selects active. Once loaded, it sets the direction and starting word of a burst. Later continue cycles step through the low two address bits, in linear or interleaved order, and wrap back to the starting word after four beats. Byte-lane write enables are sampled on every write beat. An inactive clock enable freezes the whole block for that edge. The read bus is driven only when output enable is asserted and a read beat is in the output register.

Top module: `zbt_burst_sram`

## Requirements
- R1: While `rst_n` is low at an edge, both pipeline stages and the output register are cleared, the burst ends, and no pending write reaches the array. After reset, `rd_drive` stays low until a read completes its latency.
- R2: A selected load (`burst_next`=0) with `wr_sel_n`=1 at edge N is a read. Its word appears on `rd_data` with `rd_drive`=1 after edge N+2, provided `drive_en_n`=0.
- R3: A selected load with `wr_sel_n`=0 at edge N is a write. `lane_wr_n` is sampled at edge N and `wr_data` at edge N+2. Byte lane i (bits 8i+7..8i) is written only when `lane_wr_n[i]`=0; the other lanes keep their old contents.
- R4: With `order_linear`=1 at load, each continue beat k (k=1,2,3,...) uses the low address bits (start+k) mod 4. The upper address bits stay those loaded.
- R5: With `order_linear`=0 at load, each continue beat k uses the low address bits start XOR (k mod 4).
- R6: On continue cycles (`burst_next`=1), `wr_sel_n` is ignored. The beat keeps the direction captured at load, and each write beat uses the `lane_wr_n` sampled on its own cycle.
- R7: After the fourth beat the burst wraps: beat 4 addresses the starting word again and the sequence repeats.
- R8: A load during a burst ends that burst at once; the next continue follows the new load.
- R9: An edge with `clk_en_n`=1 is ignored: no command is taken, no write commits, pipeline and burst state hold, and the output register holds.
- R10: A load is a deselect unless `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A deselect performs no access, and the continue cycles after it perform none either.
- R11: `rd_drive` is 1 only when `drive_en_n`=0 and a read beat sits in the output register. When `rd_drive` is 0, `rd_data` is all zeros.
- R12: A read loaded on the edge right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high ignores the edge |
| burst_next | input | 1 | 0 loads a new command, 1 continues the burst |
| wr_sel_n | input | 1 | At load: 0 write, 1 read |
| cmd_addr | input | ADDR_W | Word address of a new command |
| lane_wr_n | input | NBYTES | Active-low per-byte write enables |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b | input | 1 | Active-high chip select |
| sel_c_n | input | 1 | Active-low chip select |
| order_linear | input | 1 | At load: 1 linear, 0 interleaved burst order |
| drive_en_n | input | 1 | Active-low read output enable |
| wr_data | input | DATA_W | Write data, sampled two edges after its command |
| rd_data | output | DATA_W | Read data, zero when not driven |
| rd_drive | output | 1 | Read bus driven with a valid read beat |

## Verification
The hardest situation to reach is a clock-enable stall in the middle of a wrapping burst that mixes directions: a write burst whose data phase still lies ahead, a read loaded right behind it, and a frozen edge between them. The stall must hold every stage without losing or repeating a beat. Long constrained-random runs reach this mix. They bias toward continue cycles, occasional stalls, partial byte enables and deselects over a small address space so that addresses collide often. A reference pipeline in the bench predicts every output cycle. Directed sequences pin down each burst order, the wrap, a pending write cut off by reset, and a read right after a write.

// File: rtl/zbt_pkg.sv
// Package: shared burst-order type and beat address helper.
// Assumes bursts are four beats, so only two address bits advance.
package zbt_pkg;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    // Low address bits for beat number `beat` of a burst starting at `start`.
    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input burst_order_e ord);
        logic [1:0] r;
        if (ord == ORD_LINEAR) r = 2'(start + beat);
        else                   r = start ^ beat;
        return r;
    endfunction

endpackage

// File: rtl/zbt_cmd_ctrl.sv
// Command front end: decides each enabled edge's access.
// A load takes address, direction and order; a continue steps the burst
// counter and reuses the loaded direction. Assumes ADDR_W >= 2.
module zbt_cmd_ctrl
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              selected,
    input  logic              rd_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] bw_n,
    input  logic              order_lin,
    output logic              iss_valid,
    output logic              iss_write,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [NBYTES-1:0] iss_bw_n
);

    logic              burst_act_q;
    logic              burst_wr_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        beat_q;
    burst_order_e      order_q;
    logic [1:0]        next_beat;

    assign next_beat = 2'(beat_q + 2'd1);
    assign iss_bw_n  = bw_n;

    // Select the access for this edge: a fresh load or the next burst beat.
    always_comb begin
        if (load) begin
            iss_valid = selected;
            iss_write = ~rd_wr_n;
            iss_addr  = addr;
        end else begin
            iss_valid = burst_act_q;
            iss_write = burst_wr_q;
            iss_addr  = {base_q[ADDR_W-1:2],
                         beat_offset(base_q[1:0], next_beat, order_q)};
        end
    end

    // Burst state: captured at load, stepped on each continue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_act_q <= 1'b0;
            burst_wr_q  <= 1'b0;
            base_q      <= '0;
            beat_q      <= 2'd0;
            order_q     <= ORD_LINEAR;
        end else if (en) begin
            if (load) begin
                burst_act_q <= selected;
                burst_wr_q  <= ~rd_wr_n;
                base_q      <= addr;
                beat_q      <= 2'd0;
                order_q     <= burst_order_e'(order_lin);
            end else if (burst_act_q) begin
                beat_q <= next_beat;
            end
        end
    end

    AST_DESEL_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load && !selected) |=> !burst_act_q); // R10
    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !burst_act_q) |-> !iss_valid); // R10
    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && burst_act_q && beat_q == 2'd3) |=> beat_q == 2'd0); // R7
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> $stable(burst_wr_q)); // R6
    AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(beat_q) && $stable(base_q)); // R9

endmodule

// File: rtl/zbt_pipe.sv
// Fixed-latency command delay line between issue and data phase.
// Holds all stages when disabled; reset empties every stage.
module zbt_pipe #(
    parameter int W      = 11,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic         v_q [STAGES];
    logic [W-1:0] d_q [STAGES];

    // Shift the command one stage per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                v_q[s] <= 1'b0;
                d_q[s] <= '0;
            end
        end else if (en) begin
            v_q[0] <= in_valid;
            d_q[0] <= in_data;
            for (int s = 1; s < STAGES; s++) begin
                v_q[s] <= v_q[s-1];
                d_q[s] <= d_q[s-1];
            end
        end
    end

    assign out_valid = v_q[STAGES-1];
    assign out_data  = d_q[STAGES-1];

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !out_valid); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(out_valid) && $stable(out_data)); // R9

endmodule

// File: rtl/zbt_array.sv
// Storage array with per-byte-lane write and a registered read port.
// Assumes the data phase command arrives already aligned with wr_data.
module zbt_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     op_valid,
    input  logic                     op_write,
    input  logic [ADDR_W-1:0]        op_addr,
    input  logic [NBYTES-1:0]        op_bw_n,
    input  logic [NBYTES*BYTE_W-1:0] wdata,
    output logic                     rd_valid,
    output logic [NBYTES*BYTE_W-1:0] rd_data
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = NBYTES * BYTE_W;

    logic [DATA_W-1:0] rd_word;
    logic              commit;

    assign commit = rst_n && en && op_valid && op_write;

    for (genvar l = 0; l < NBYTES; l++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        // Write this byte lane when its enable is active.
        always_ff @(posedge clk) begin
            if (commit && !op_bw_n[l]) lane_mem[op_addr] <= wdata[l*BYTE_W +: BYTE_W];
        end

        assign rd_word[l*BYTE_W +: BYTE_W] = lane_mem[op_addr];
    end

    // Register read data at the data phase of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (en) begin
            rd_valid <= op_valid && !op_write;
            rd_data  <= rd_word;
        end
    end

    AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_valid && !op_write) |=> rd_valid); // R2
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op_valid && op_write) |=> !rd_valid); // R3

endmodule

// File: rtl/zbt_burst_sram.sv
// Top level: zero-turnaround pipelined burst SRAM.
// The command edge and data phase are STAGES edges apart for reads and writes
// alike. Assumes inputs are synchronous to clk.
module zbt_burst_sram #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 8,
    parameter int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              burst_next,
    input  logic              wr_sel_n,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [NBYTES-1:0] lane_wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              order_linear,
    input  logic              drive_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);

    localparam int STAGES = 2;
    localparam int PW     = 1 + ADDR_W + NBYTES;

    logic              en;
    logic              selected;
    logic              iss_valid, iss_write;
    logic [ADDR_W-1:0] iss_addr;
    logic [NBYTES-1:0] iss_bw_n;
    logic              p_valid;
    logic [PW-1:0]     p_data;
    logic              p_write;
    logic [ADDR_W-1:0] p_addr;
    logic [NBYTES-1:0] p_bw_n;
    logic              arr_valid;
    logic [DATA_W-1:0] arr_data;

    assign en       = ~clk_en_n;
    assign selected = ~sel_a_n & sel_b & ~sel_c_n;

    zbt_cmd_ctrl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .load      (~burst_next),
        .selected  (selected),
        .rd_wr_n   (wr_sel_n),
        .addr      (cmd_addr),
        .bw_n      (lane_wr_n),
        .order_lin (order_linear),
        .iss_valid (iss_valid),
        .iss_write (iss_write),
        .iss_addr  (iss_addr),
        .iss_bw_n  (iss_bw_n)
    );

    zbt_pipe #(.W(PW), .STAGES(STAGES)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .in_valid  (iss_valid),
        .in_data   ({iss_write, iss_addr, iss_bw_n}),
        .out_valid (p_valid),
        .out_data  (p_data)
    );

    assign {p_write, p_addr, p_bw_n} = p_data;

    zbt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .op_valid (p_valid),
        .op_write (p_write),
        .op_addr  (p_addr),
        .op_bw_n  (p_bw_n),
        .wdata    (wr_data),
        .rd_valid (arr_valid),
        .rd_data  (arr_data)
    );

    // Gate the read bus with output enable; undriven reads as zero.
    always_comb begin
        rd_drive = arr_valid & ~drive_en_n;
        rd_data  = rd_drive ? arr_data : '0;
    end

    AST_FREEZE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(arr_valid) && $stable(arr_data)); // R9
    AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |-> (rd_data == '0)); // R11

endmodule

// File: tb/sim_zbt_burst_sram.sv
// Bench: reference pipeline model, directed corner cases and seeded random mix.
module sim_zbt_burst_sram;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0, burst_next = 1'b0, wr_sel_n = 1'b1;
    logic [AW-1:0] cmd_addr = '0;
    logic [NB-1:0] lane_wr_n = '0;
    logic          sel_a_n = 1'b1, sel_b = 1'b1, sel_c_n = 1'b0;
    logic          order_linear = 1'b1, drive_en_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int checks = 0;
    int fails  = 0;

    zbt_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(8)) u0 (.*);

    always #5 clk = ~clk;

    // Reference model state.
    logic [DW-1:0] ref_mem [1<<AW];
    logic          m1_v = 0, m1_w = 0, m2_v = 0, m2_w = 0;
    logic [AW-1:0] m1_a = '0, m2_a = '0;
    logic [NB-1:0] m1_b = '0, m2_b = '0;
    logic          b_act = 0, b_w = 0, b_lin = 1;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;
    logic          ev = 0;
    logic [DW-1:0] ed = '0;

    task automatic model_edge(input logic [DW-1:0] wd);
        logic nv, nw, sel;
        logic [AW-1:0] na;
        logic [1:0] off;
        ev = m2_v && !m2_w;
        if (ev) ed = ref_mem[m2_a];
        if (m2_v && m2_w)
            for (int l = 0; l < NB; l++)
                if (!m2_b[l]) ref_mem[m2_a][l*8 +: 8] = wd[l*8 +: 8];
        m2_v = m1_v; m2_w = m1_w; m2_a = m1_a; m2_b = m1_b;
        sel = !sel_a_n && sel_b && !sel_c_n;
        if (!burst_next) begin
            nv = sel; nw = !wr_sel_n; na = cmd_addr;
            b_act = sel; b_w = !wr_sel_n; b_base = cmd_addr; b_cnt = 2'd0; b_lin = order_linear;
        end else begin
            nv = b_act; nw = b_w;
            if (b_act) b_cnt = 2'(b_cnt + 1);
            off = b_lin ? 2'(b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt);
            na = {b_base[AW-1:2], off};
        end
        m1_v = nv; m1_w = nw; m1_a = na; m1_b = lane_wr_n;
    endtask

    task automatic check(input string tag);
        logic          xd;
        logic [DW-1:0] xv;
        xd = ev && !drive_en_n;
        xv = xd ? ed : '0;
        checks++;
        if (rd_drive !== xd || rd_data !== xv) begin
            fails++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     tag, rd_drive, rd_data, xd, xv);
        end
    endtask

    // One clock: inputs already driven at the falling edge.
    task automatic tick(input string tag);
        logic [DW-1:0] wd;
        wd = $urandom;
        wr_data = wd;
        @(posedge clk);
        if (!rst_n) begin
            m1_v = 0; m2_v = 0; b_act = 0; ev = 0;
        end else if (!clk_en_n) begin
            model_edge(wd);
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic defaults();
        clk_en_n = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        drive_en_n = 0; lane_wr_n = '0;
    endtask

    task automatic load(input logic [AW-1:0] a, input logic wr, input logic lin, input string tag);
        defaults(); burst_next = 0; wr_sel_n = !wr; cmd_addr = a; order_linear = lin;
        tick(tag);
    endtask

    task automatic adv(input string tag);
        defaults(); burst_next = 1; wr_sel_n = $urandom_range(0, 1);
        tick(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            defaults(); sel_a_n = 1; burst_next = 0; tick(tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        defaults(); sel_a_n = 1;
        tick("R1"); tick("R1");
        rst_n = 1;
        idle(3, "R1");
        // Fill every word so later reads are defined.
        for (int a = 0; a < (1<<AW); a++) load(AW'(a), 1, 1, "R3");
        idle(3, "R3");

        // R2 single read.
        load(6'd10, 0, 1, "R2"); idle(3, "R2");
        // R3 partial-lane write then read back.
        defaults(); burst_next = 0; wr_sel_n = 0; cmd_addr = 6'd10; lane_wr_n = 4'b1010; tick("R3");
        idle(2, "R3"); load(6'd10, 0, 1, "R3"); idle(3, "R3");
        // R12 read right after write to same word.
        load(6'd20, 1, 1, "R12"); load(6'd20, 0, 1, "R12"); idle(3, "R12");
        // R4 linear burst from offset 1, then R7 wrap beats.
        load(6'd13, 0, 1, "R4"); repeat (3) adv("R4"); repeat (3) adv("R7"); idle(3, "R7");
        // R5 interleaved burst from offset 2.
        load(6'd14, 0, 0, "R5"); repeat (5) adv("R5"); idle(3, "R5");
        // R6 write burst with random read/write select during continues.
        load(6'd33, 1, 0, "R6"); repeat (3) adv("R6");
        load(6'd33, 0, 0, "R6"); repeat (3) adv("R6"); idle(3, "R6");
        // R8 load in mid-burst.
        load(6'd40, 0, 1, "R8"); adv("R8"); load(6'd51, 0, 0, "R8"); repeat (3) adv("R8"); idle(3, "R8");
        // R9 stalls inside a read burst.
        load(6'd4, 0, 1, "R9"); adv("R9");
        defaults(); clk_en_n = 1; burst_next = 0; wr_sel_n = 0; cmd_addr = 6'd4; tick("R9"); tick("R9");
        adv("R9"); adv("R9"); idle(3, "R9");
        // R10 each select inactive at a write load, then continues, then read back.
        for (int k = 0; k < 3; k++) begin
            defaults(); burst_next = 0; wr_sel_n = 0; cmd_addr = 6'd8;
            if (k == 0) sel_a_n = 1; else if (k == 1) sel_b = 0; else sel_c_n = 1;
            tick("R10"); adv("R10"); adv("R10");
        end
        idle(2, "R10"); load(6'd8, 0, 1, "R10"); repeat (3) adv("R10"); idle(3, "R10");
        // R11 output enable high while read beats land.
        load(6'd24, 0, 1, "R11"); adv("R11");
        defaults(); drive_en_n = 1; burst_next = 1; tick("R11"); tick("R11");
        drive_en_n = 0; tick("R11"); idle(2, "R11");
        // R1 pending write cut off by reset.
        load(6'd30, 0, 1, "R1"); idle(3, "R1");
        load(6'd30, 1, 1, "R1");
        rst_n = 0; idle(2, "R1"); rst_n = 1;
        idle(2, "R1"); load(6'd30, 0, 1, "R1"); idle(3, "R1");

        // Seeded random mix.
        for (int i = 0; i < 4000; i++) begin
            string tag;
            clk_en_n     = ($urandom_range(0, 9) == 0);
            burst_next   = ($urandom_range(0, 9) < 5);
            wr_sel_n     = $urandom_range(0, 1);
            cmd_addr     = AW'($urandom_range(0, 15));
            lane_wr_n    = NB'($urandom);
            sel_a_n      = ($urandom_range(0, 11) == 0);
            sel_b        = ($urandom_range(0, 11) != 0);
            sel_c_n      = ($urandom_range(0, 11) == 0);
            order_linear = $urandom_range(0, 1);
            drive_en_n   = ($urandom_range(0, 6) == 0);
            if (clk_en_n) tag = "R9";
            else if (burst_next) tag = "R6";
            else if (sel_a_n || !sel_b || sel_c_n) tag = "R10";
            else tag = "R12";
            tick(tag);
        end
        idle(3, "R2");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule